// File: doc/BRIEF.md
# Exception Entry Sequencer with Banked Registers

This block steers a processor into and out of its privileged firmware mode. On a take strobe it receives an exception index, the interrupted PC and the firmware base address. One cycle later it presents a PC-load request. The request carries the firmware entry address, formed as the base plus an offset chosen by the index. It also carries the saved return address, which is the interrupted PC with bit 0 replaced by the mode flag that held before entry.

Eight general registers are banked. These are registers 8 to 14 and register 25, carried in slots 0 to 7 in that order. The block keeps the shadow copies. An exchange happens only on the transition between user mode and privileged mode, in either direction. In the same cycle as the strobe, the block drives the shadow values onto the register-file write port. At that clock edge it captures the current register values into the shadow bank, so the swap completes in a single cycle. An exit strobe with a return address leaves privileged mode: bit 0 of the return address chooses the mode to resume in. An index that has no entry point raises a one-cycle abort and changes nothing.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, priv_o is 1 and pc_load_o, abort_o and gpr_we_o are 0.
- R2: One cycle after an accepted take, exc_addr_o equals pc_i with bit 0 replaced by the value priv_o had when the take was sampled.
- R3: Indices 0x80 to 0xBF are user-callable firmware calls. For these, new_pc_o = fw_base_i + 0x2000 + (index - 0x80) * 64, with pc_load_o high for one cycle.
- R4: Indices 0x00 to 0x3F are privileged firmware calls. For these, new_pc_o = fw_base_i + 0x1000 + index * 64.
- R5: Indices 0x40 to 0x44 are, in that order: reset, machine check, interrupt, memory fault and arithmetic trap. They enter at fw_base_i plus 0x000, 0x080, 0x100, 0x180 and 0x200 respectively.
- R6: Any other index (0x45 to 0x7F, 0xC0 to 0xFF) raises abort_o for one cycle after the take. In that case pc_load_o stays 0, priv_o, new_pc_o and exc_addr_o keep their values, and no swap occurs.
- R7: An accepted take while priv_o is 0 swaps the banks. In the strobe cycle, gpr_we_o is 1 and slot k of gpr_wdata_o carries shadow slot k. The shadow bank captures gpr_rdata_i at that edge, and priv_o becomes 1.
- R8: An accepted take while priv_o is 1 leaves gpr_we_o at 0, and priv_o stays 1.
- R9: An exit while priv_o is 1 loads new_pc_o with ret_addr_i with bit 0 cleared, and sets priv_o to ret_addr_i bit 0. The banks are swapped only when that bit is 0.
- R10: An exit while priv_o is 0 has no effect. When take_i and exit_i are high together, the exit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Take-exception strobe |
| exc_idx_i | input | 8 | Exception or firmware-call index |
| pc_i | input | XLEN | PC of the interrupted instruction |
| fw_base_i | input | XLEN | Firmware base address |
| exit_i | input | 1 | Leave-privileged-mode strobe |
| ret_addr_i | input | XLEN | Return address; bit 0 is the mode to resume |
| gpr_rdata_i | input | 8*XLEN | Current values of the eight banked registers, slot 0 in the low bits |
| gpr_we_o | output | 1 | Write strobe for the eight banked registers |
| gpr_wdata_o | output | 8*XLEN | Shadow values to write, slot 0 in the low bits |
| new_pc_o | output | XLEN | PC to resume fetching from |
| exc_addr_o | output | XLEN | Saved exception address |
| pc_load_o | output | 1 | new_pc_o is to be loaded this cycle |
| priv_o | output | 1 | Privileged-mode flag |
| abort_o | output | 1 | Unmapped index was taken |

## Verification
The register-file write strobe and its data are combinational. They are due in the same cycle as the take or exit strobe, so the bench samples them shortly after it drives its inputs and before the clock edge. The remaining outputs are registered: new_pc_o, exc_addr_o, pc_load_o, priv_o and abort_o are due one edge after the strobe. The bench compares them with its reference model at the following falling edge, on every clock. The bench holds the register file itself and applies each write at the edge. A broken swap therefore shows up as wrong write data on the next transition.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [7:0]        exc_idx_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   fw_base_i,
  input  logic              exit_i,
  input  logic [XLEN-1:0]   ret_addr_i,
  input  logic [8*XLEN-1:0] gpr_rdata_i,
  output logic              gpr_we_o,
  output logic [8*XLEN-1:0] gpr_wdata_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   exc_addr_o,
  output logic              pc_load_o,
  output logic              priv_o,
  output logic              abort_o
);
  localparam int NBANK = 8;
  localparam int OFFW  = 14;

  logic            priv_q;
  logic            mapped;
  logic [OFFW-1:0] off;
  logic            enter, leave, swap;

  always_comb begin
    mapped = 1'b1;
    off    = '0;
    if (exc_idx_i[7]) begin
      if (exc_idx_i[6]) mapped = 1'b0;
      else off = 14'h2000 + {2'b00, exc_idx_i[5:0], 6'b0};
    end else if (!exc_idx_i[6]) begin
      off = 14'h1000 + {2'b00, exc_idx_i[5:0], 6'b0};
    end else begin
      case (exc_idx_i[5:0])
        6'd0:    off = 14'h0000;
        6'd1:    off = 14'h0080;
        6'd2:    off = 14'h0100;
        6'd3:    off = 14'h0180;
        6'd4:    off = 14'h0200;
        default: mapped = 1'b0;
      endcase
    end
  end

  assign enter    = take_i & mapped;
  assign leave    = exit_i & ~take_i & priv_q;
  assign swap     = (enter & ~priv_q) | (leave & ~ret_addr_i[0]);
  assign gpr_we_o = swap;
  assign priv_o   = priv_q;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic [XLEN-1:0] shadow_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    shadow_q <= '0;
      else if (swap) shadow_q <= gpr_rdata_i[k*XLEN +: XLEN];
    end
    assign gpr_wdata_o[k*XLEN +: XLEN] = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q     <= 1'b1;
      pc_load_o  <= 1'b0;
      abort_o    <= 1'b0;
      new_pc_o   <= '0;
      exc_addr_o <= '0;
    end else begin
      pc_load_o <= enter | leave;
      abort_o   <= take_i & ~mapped;
      if (enter) begin
        new_pc_o   <= fw_base_i + XLEN'(off);
        exc_addr_o <= {pc_i[XLEN-1:1], priv_q};
        priv_q     <= 1'b1;
      end else if (leave) begin
        new_pc_o <= {ret_addr_i[XLEN-1:1], 1'b0};
        priv_q   <= ret_addr_i[0];
      end
    end
  end
endmodule

module exc_entry_seq_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_i,
  input logic [7:0]        exc_idx_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   fw_base_i,
  input logic              exit_i,
  input logic [XLEN-1:0]   ret_addr_i,
  input logic [8*XLEN-1:0] gpr_rdata_i,
  input logic              gpr_we_o,
  input logic [8*XLEN-1:0] gpr_wdata_o,
  input logic [XLEN-1:0]   new_pc_o,
  input logic [XLEN-1:0]   exc_addr_o,
  input logic              pc_load_o,
  input logic              priv_o,
  input logic              abort_o
);
  a_r2_saved_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o && $past(take_i) |-> exc_addr_o[0] == $past(priv_o));

  a_r6_abort_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !pc_load_o);

  a_r7_swap_enters_priv: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we_o && take_i |=> priv_o);

  a_r8_no_swap_in_priv: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && priv_o |-> !gpr_we_o);

  a_r9_exit_to_user: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o && exit_i && !take_i && !ret_addr_i[0] |=> !priv_o);

  a_r10_user_exit_inert: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i && !take_i && !priv_o |-> !gpr_we_o);

  a_r10_user_exit_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i && !take_i && !priv_o |=> !pc_load_o);

  a_r7_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we_o |-> take_i || exit_i);

  a_r9_mode_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i && !exit_i |=> $stable(priv_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take_i = 1'b0, exit_i = 1'b0;
  logic [7:0] exc_idx_i = '0;
  logic [XLEN-1:0] pc_i = '0, fw_base_i = '0, ret_addr_i = '0;
  logic [8*XLEN-1:0] gpr_rdata_i, gpr_wdata_o;
  logic gpr_we_o, pc_load_o, priv_o, abort_o;
  logic [XLEN-1:0] new_pc_o, exc_addr_o;

  always #4 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN)) dut (.*);

  logic [XLEN-1:0] rf [8];
  logic [XLEN-1:0] sh [8];
  logic m_priv, m_load, m_abort;
  logic [XLEN-1:0] m_npc, m_exc;
  int checks = 0, fails = 0;

  always_comb for (int k = 0; k < 8; k++) gpr_rdata_i[k*XLEN +: XLEN] = rf[k];

  task automatic cmp(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit entry_of(logic [7:0] idx, output logic [XLEN-1:0] off);
    int i = idx;
    off = '0;
    if (i >= 128 && i < 192) begin off = XLEN'(8192 + (i - 128) * 64); return 1; end
    if (i < 64) begin off = XLEN'(4096 + i * 64); return 1; end
    if (i >= 64 && i <= 68) begin off = XLEN'((i - 64) * 128); return 1; end
    return 0;
  endfunction

  task automatic check_regs(string tag);
    cmp(tag, "priv", XLEN'(priv_o), XLEN'(m_priv));
    cmp(tag, "pc_load", XLEN'(pc_load_o), XLEN'(m_load));
    cmp(tag, "abort", XLEN'(abort_o), XLEN'(m_abort));
    cmp(tag, "new_pc", new_pc_o, m_npc);
    cmp(tag, "exc_addr", exc_addr_o, m_exc);
  endtask

  task automatic step(string tag, logic t, logic [7:0] idx, logic [XLEN-1:0] pc,
                      logic [XLEN-1:0] base, logic x, logic [XLEN-1:0] ret);
    logic [XLEN-1:0] off, tmp;
    bit ok, we, ent, lv;
    take_i = t; exc_idx_i = idx; pc_i = pc; fw_base_i = base; exit_i = x; ret_addr_i = ret;
    ok  = entry_of(idx, off);
    ent = t && ok;
    lv  = !t && x && m_priv;
    we  = (ent && !m_priv) || (lv && !ret[0]);
    #1;
    cmp(tag, "gpr_we", XLEN'(gpr_we_o), XLEN'(we));
    if (we) for (int k = 0; k < 8; k++) cmp(tag, "wdata", gpr_wdata_o[k*XLEN +: XLEN], sh[k]);
    @(posedge clk); #1;
    if (we) for (int k = 0; k < 8; k++) begin tmp = rf[k]; rf[k] = sh[k]; sh[k] = tmp; end
    m_load = ent || lv;
    m_abort = t && !ok;
    if (ent) begin
      m_npc = base + off;
      m_exc = {pc[XLEN-1:1], m_priv};
      m_priv = 1'b1;
    end else if (lv) begin
      m_npc = {ret[XLEN-1:1], 1'b0};
      m_priv = ret[0];
    end
    take_i = 0; exit_i = 0;
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic fill_rf(int seed);
    for (int k = 0; k < 8; k++) rf[k] = {32'(seed), 32'(k * 16 + 5)} ^ 64'hA5A5_0000_0000_1111;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) sh[k] = '0;
    fill_rf(1);
    m_priv = 1; m_load = 0; m_abort = 0; m_npc = '0; m_exc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");
    cmp("R1", "gpr_we", XLEN'(gpr_we_o), '0);

    step("R9", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0000_3001);
    step("R9", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0000_4000);
    fill_rf(2);
    step("R3", 1, 8'h85, 64'h0000_0000_0010_0001, 64'h0000_0000_8000_0000, 0, '0);
    step("R8", 1, 8'h42, 64'h0000_0000_0020_0000, 64'h0000_0000_8000_0000, 0, '0);
    step("R4", 1, 8'h00, 64'h0000_0000_0030_0000, 64'h0000_0001_0000_0000, 0, '0);
    step("R4", 1, 8'h3F, 64'h0000_0000_0030_0004, 64'h0000_0001_0000_0000, 0, '0);
    for (int i = 64; i < 69; i++)
      step("R5", 1, 8'(i), 64'h0000_0000_0040_0008, 64'h0000_0002_0000_0000, 0, '0);
    step("R3", 1, 8'h80, 64'h10, 64'h0000_0003_0000_0000, 0, '0);
    step("R3", 1, 8'hBF, 64'h10, 64'h0000_0003_0000_0000, 0, '0);
    step("R6", 1, 8'h45, 64'h99, 64'h1000, 0, '0);
    step("R6", 1, 8'h7F, 64'h99, 64'h1000, 0, '0);
    step("R6", 1, 8'hC0, 64'h99, 64'h1000, 0, '0);
    step("R6", 1, 8'hFF, 64'h99, 64'h1000, 0, '0);
    fill_rf(3);
    step("R9", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0050_0000);
    step("R10", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0060_0000);
    step("R10", 1, 8'h90, 64'h0000_0000_0070_0000, 64'h4000, 1, 64'h0000_0000_0060_0000);
    step("R9", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0050_0002);
    step("R6", 1, 8'hD0, 64'h0000_0000_0070_0000, 64'h4000, 0, '0);
    step("R7", 1, 8'h43, 64'h0000_0000_0070_0000, 64'h4000, 0, '0);
    for (int i = 0; i < 256; i++) begin
      fill_rf(i + 10);
      step("R7", 1, 8'(i), 64'h0000_0000_1234_5670 + 64'(i), 64'h0000_0010_0000_0000, 0, '0);
      step("R9", 0, 8'h00, '0, '0, 1, 64'h0000_0000_0800_0000 + 64'(i * 2));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule